// File: doc/BRIEF.md
# Supply-Aware Memory Access Gate

This block sits between a memory access controller and a non-volatile memory whose writes are only safe while its supplies are within range. Three comparator indications arrive from the analog side: the core supply has passed the restart level, the core supply has fallen under its write-inhibit floor, and the I/O supply has fallen under its own floor. After two-flop synchronization, a three-state sequencer decides whether the host may reach the memory. While it is not running, the memory's active-low chip enable and write enable are held high. No host request gets through.

Recovery uses hysteresis. The sequencer leaves the inhibited state only when the core supply is above the restart level and neither floor indication is active. It then counts a full start-up delay before it lets accesses through. Once running, it continues as long as neither floor indication is active, even if the supply falls under the restart level. Any floor indication during the start-up count returns it to the inhibited state. A floor indication while running does the same, and also raises a one-cycle abort pulse so that the access controller drops any write in progress. Each brownout re-arms the whole sequence.

Top module: `supply_gate_seq`

## Requirements
- R1: During and right after reset the gate is inhibited: mem_ready=0, mem_ce_n=1, mem_we_n=1 and access_abort=0.
- R2: Whenever mem_ready is 0, mem_ce_n and mem_we_n are both 1, whatever host_ce_n and host_we_n are.
- R3: Whenever mem_ready is 1, mem_ce_n equals host_ce_n and mem_we_n equals host_we_n, for all four combinations.
- R4: From the inhibited state, with core_above_restart=1 and both floor inputs 0, mem_ready rises exactly DELAY_CYCLES+3 clock edges after the inputs change. Two edges go to synchronization and one to the state register. DELAY_CYCLES is (CLK_FREQ_HZ/1e6)*STARTUP_US.
- R5: Once mem_ready is 1, a drop of core_above_restart to 0 does not clear it while both floor inputs stay 0.
- R6: A core_below_floor=1 while running clears mem_ready on the third clock edge after the input change. On that same edge access_abort goes to 1 for exactly one cycle.
- R7: An io_below_floor=1 while running has the same effect as R6: mem_ready drops and a single one-cycle abort pulse is produced.
- R8: A floor indication that reaches the sequencer during the start-up count sends it back to the inhibited state. A later recovery again takes the full DELAY_CYCLES+3 edges, counted from the moment the inputs are clear.
- R9: access_abort is produced only when leaving the running state. An interrupted start-up produces none.
- R10: After a brownout, clearing the floor inputs alone does not restart the sequence. mem_ready stays 0 until core_above_restart is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_above_restart | input | 1 | Asynchronous comparator: core supply above restart level |
| core_below_floor | input | 1 | Asynchronous comparator: core supply below write-inhibit floor |
| io_below_floor | input | 1 | Asynchronous comparator: I/O supply below write-inhibit floor |
| host_ce_n | input | 1 | Chip enable requested by the access controller, active low |
| host_we_n | input | 1 | Write enable requested by the access controller, active low |
| mem_ce_n | output | 1 | Chip enable toward the memory, forced high unless running |
| mem_we_n | output | 1 | Write enable toward the memory, forced high unless running |
| mem_ready | output | 1 | High only in the running state |
| access_abort | output | 1 | One-cycle pulse when a brownout ends the running state |

## Verification
The hardest case to reach from the ports is a floor indication that lands inside the start-up count. It has to arrive late enough that the count is under way and early enough that it reaches the sequencer before the count finishes. The bench uses a short delay and sweeps the injection point over every start-up cycle where it can still land in time. For each point it checks three things: the gate never became ready, no abort pulse appeared, and the full latency is paid again after the indication clears.

// File: rtl/supgate_pkg.sv
// Shared types for the supply-aware memory access gate.
package supgate_pkg;

    // Sequencer states: inhibited, counting start-up delay, running.
    typedef enum logic [1:0] {
        SG_INHIBIT = 2'd0,
        SG_STARTUP = 2'd1,
        SG_RUN     = 2'd2
    } sg_state_e;

endpackage

// File: rtl/supgate_sync.sv
// Multi-bit synchronizer: each bit passes through its own chain of STAGES
// flip-flops. Assumes the bits are independent quasi-static levels. The
// reset value of each bit is chosen by RST_VAL so that reset reads as safe.
module supgate_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], din[b]};
        end

        assign dout[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/supgate_timer.sv
// Start-up delay counter. It counts while run is high and clears otherwise.
// done is high in the last of LIMIT consecutive run cycles. Assumes LIMIT >= 2.
module supgate_timer #(
    parameter int LIMIT = 100000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    logic [CW-1:0] cnt;

    // Advance while running, restart from zero whenever run drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/supgate_fsm.sv
// Supply sequencer. It leaves INHIBIT only on restart-level-and-no-floor and
// waits for the timer in STARTUP. It stays in RUN until a floor indication
// arrives. Inputs are assumed already synchronized.
module supgate_fsm
    import supgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart_ok,
    input  logic      floor_hit,
    input  logic      delay_done,
    output sg_state_e state,
    output logic      abort_pulse
);

    sg_state_e nxt;

    // Next-state selection with hysteresis between restart and floor levels.
    always_comb begin
        nxt = state;
        unique case (state)
            SG_INHIBIT: if (restart_ok && !floor_hit) nxt = SG_STARTUP;
            SG_STARTUP: begin
                if (floor_hit)       nxt = SG_INHIBIT;
                else if (delay_done) nxt = SG_RUN;
            end
            SG_RUN:     if (floor_hit) nxt = SG_INHIBIT;
            default:    nxt = SG_INHIBIT;
        endcase
    end

    // State register and one-cycle abort on leaving RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SG_INHIBIT;
            abort_pulse <= 1'b0;
        end else begin
            state       <= nxt;
            abort_pulse <= (state == SG_RUN) && floor_hit;
        end
    end

endmodule

// File: rtl/supply_gate_seq.sv
// Supply-aware memory access gate (top). Synchronizes the comparator levels
// and runs the sequencer. Host chip enable and write enable pass through only
// in the running state. Assumes CLK_FREQ_HZ is a multiple of 1 MHz and that
// the resulting DELAY_CYCLES is at least 2.
module supply_gate_seq
    import supgate_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int STARTUP_US  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_above_restart,
    input  logic core_below_floor,
    input  logic io_below_floor,
    input  logic host_ce_n,
    input  logic host_we_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_ready,
    output logic access_abort
);

    localparam int DELAY_CYCLES = (CLK_FREQ_HZ / 1_000_000) * STARTUP_US;

    logic [2:0] cmp_s;
    logic       floor_hit;
    logic       delay_done;
    sg_state_e  state;

    // Reset reads as "below restart, below both floors".
    supgate_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({io_below_floor, core_below_floor, core_above_restart}),
        .dout  (cmp_s)
    );

    assign floor_hit = cmp_s[1] | cmp_s[2];

    supgate_timer #(.LIMIT(DELAY_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == SG_STARTUP),
        .done  (delay_done)
    );

    supgate_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_ok  (cmp_s[0]),
        .floor_hit   (floor_hit),
        .delay_done  (delay_done),
        .state       (state),
        .abort_pulse (access_abort)
    );

    // Gate host strobes: forced inactive outside the running state.
    assign mem_ready = (state == SG_RUN);
    assign mem_ce_n  = host_ce_n | ~mem_ready;
    assign mem_we_n  = host_we_n | ~mem_ready;

endmodule

// File: rtl/supgate_chk.sv
// Port-level checker for supply_gate_seq, attached by bind below.
module supgate_chk #(
    parameter int DLY = 100000
) (
    input logic clk,
    input logic rst_n,
    input logic host_ce_n,
    input logic host_we_n,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic mem_ready,
    input logic access_abort
);

    localparam int LW = $clog2(DLY + 2);
    logic [LW-1:0] low_run;

    // Saturating count of consecutive cycles with mem_ready low.
    always_ff @(posedge clk) begin
        if (!rst_n || mem_ready)     low_run <= '0;
        else if (low_run != LW'(DLY)) low_run <= low_run + 1'b1;
    end

    // R2
    strobes_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> (mem_ce_n && mem_we_n));

    // R3
    strobes_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> (mem_ce_n == host_ce_n && mem_we_n == host_we_n));

    // R4
    full_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready) |-> (low_run >= LW'(DLY)));

    // R6
    abort_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ready) |-> access_abort);

    // R9
    abort_only_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_abort |-> (!mem_ready && $past(mem_ready)));

    // R6
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_abort |=> !access_abort);

endmodule

bind supply_gate_seq supgate_chk #(.DLY(DELAY_CYCLES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ce_n    (host_ce_n),
    .host_we_n    (host_we_n),
    .mem_ce_n     (mem_ce_n),
    .mem_we_n     (mem_we_n),
    .mem_ready    (mem_ready),
    .access_abort (access_abort)
);

// File: tb/supply_gate_seq_tb_top.sv
module supply_gate_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FREQ       = 1_000_000;
    localparam int US         = 12;
    localparam int DLY        = (FREQ / 1_000_000) * US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, core_low = 1'b1, io_low = 1'b1;
    logic hce_n = 1'b1, hwe_n = 1'b1;
    logic ce_n, we_n, ready, abort;

    int total = 0, bad = 0, abort_cnt = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_gate_seq #(.CLK_FREQ_HZ(FREQ), .STARTUP_US(US)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_above_restart(above), .core_below_floor(core_low),
        .io_below_floor(io_low), .host_ce_n(hce_n), .host_we_n(hwe_n),
        .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_ready(ready),
        .access_abort(abort)
    );

    // Count abort pulses and cycles; the watchdog ends a hung run.
    always @(negedge clk) begin
        if (rst_n && abort) abort_cnt++;
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Edges from now until mem_ready is seen high (limit 200).
    task automatic wait_ready(output int n);
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (ready) begin n = i; break; end
        end
    endtask

    int n, a0;

    initial begin
        // R1 reset state
        cycles(4);
        chk(!ready && ce_n && we_n && !abort, "R1", {ready, ce_n, we_n, abort}, 4'b0110);
        rst_n = 1'b1;
        cycles(1);
        chk(!ready && ce_n && we_n && !abort, "R1", {ready, ce_n, we_n, abort}, 4'b0110);

        // R10 floors clear but restart low: stays inhibited; R2 strobes blocked
        core_low = 1'b0; io_low = 1'b0; hce_n = 1'b0; hwe_n = 1'b0;
        cycles(40);
        chk(!ready, "R10", ready, 0);
        chk(ce_n && we_n, "R2", {ce_n, we_n}, 2'b11);

        // R4 exact start-up latency
        above = 1'b1;
        wait_ready(n);
        chk(n == DLY + 3, "R4", n, DLY + 3);

        // R3 pass-through for all strobe combinations
        for (int v = 0; v < 4; v++) begin
            hce_n = v[0]; hwe_n = v[1];
            cycles(1);
            chk(ce_n == v[0] && we_n == v[1], "R3", {ce_n, we_n}, {v[0], v[1]});
        end

        // R5 hysteresis: restart level lost, still running
        above = 1'b0;
        cycles(30);
        chk(ready, "R5", ready, 1);

        // R6 core floor while running
        hce_n = 1'b0; hwe_n = 1'b0;
        a0 = abort_cnt;
        core_low = 1'b1;
        cycles(2);
        chk(ready, "R6", ready, 1);
        cycles(1);
        chk(!ready && abort, "R6", {ready, abort}, 2'b01);
        chk(ce_n && we_n, "R2", {ce_n, we_n}, 2'b11);
        cycles(1);
        chk(!abort, "R6", abort, 0);
        chk(abort_cnt - a0 == 1, "R6", abort_cnt - a0, 1);

        // R10 floor clears, restart still low: no restart
        core_low = 1'b0;
        cycles(40);
        chk(!ready, "R10", ready, 0);

        // R8 re-armed full delay after brownout
        above = 1'b1;
        wait_ready(n);
        chk(n == DLY + 3, "R8", n, DLY + 3);

        // R7 I/O floor while running
        a0 = abort_cnt;
        io_low = 1'b1;
        cycles(3);
        chk(!ready && abort, "R7", {ready, abort}, 2'b01);
        cycles(2);
        chk(abort_cnt - a0 == 1, "R7", abort_cnt - a0, 1);
        io_low = 1'b0;
        above = 1'b0;
        cycles(5);

        // R8/R9 sweep of floor pulse position inside the start-up count
        for (int k = 0; k <= DLY - 3; k++) begin
            bit seen_ready;
            seen_ready = 1'b0;
            a0 = abort_cnt;
            above = 1'b1;
            for (int i = 0; i < 3 + k; i++) begin
                @(negedge clk);
                if (ready) seen_ready = 1'b1;
            end
            io_low = (k % 2 == 0);
            core_low = (k % 2 == 1);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (ready) seen_ready = 1'b1;
            end
            io_low = 1'b0; core_low = 1'b0;
            wait_ready(n);
            chk(!seen_ready, "R8", seen_ready, 0);
            chk(n == DLY + 3, "R8", n, DLY + 3);
            chk(abort_cnt == a0, "R9", abort_cnt - a0, 0);
            // leave RUN quietly for next round via a floor pulse
            core_low = 1'b1; above = 1'b0;
            cycles(6);
            core_low = 1'b0;
            cycles(4);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule